// File: doc/BRIEF.md
# Serial Control Register Target for an Audio Tone and Volume Processor

This block is a write-only two-wire (I2C) target that receives control settings for a multi-band audio tone and volume processor and holds them in a bank of 8-bit registers. SCL and SDA are oversampled by the system clock through a synchronizer. From the sampled lines the block finds START and STOP conditions, shifts in bytes MSB first and drives an open-drain acknowledge as an active-low pull enable.

A transfer is START, a device address byte, one subaddress byte, any number of data bytes, and then STOP. The subaddress selects a register index and chooses between two modes. In the first mode every data byte rewrites the same register. In the second mode the index advances after each byte and wraps around. Indices outside the register bank are skipped without any error. Every register appears in parallel on one flat output bus, and each register returns to a defined value on reset.

Top module: `audctl_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high is START, and it restarts address reception at any point, including in the middle of a transfer (repeated START). A rising SDA while SCL is high is STOP.
- R2: An address byte equal to 1,0,0,0,0,0,`addr_sel`,0 (MSB first, bit 0 = 0 for a write) is acknowledged. The acknowledge holds `sda_oe` high while SCL is high in the ninth clock.
- R3: If an address byte does not match, or if its bit 0 is 1 (a read), it is not acknowledged. Bytes that follow are neither acknowledged nor written until the next START.
- R4: The byte after a matched address is the subaddress. Bits 3..0 give the register index, bit 7 is the increment flag and bits 6..4 have no effect. The subaddress is acknowledged.
- R5: When bit 7 of the subaddress is 0, every data byte is written to the one selected register, so the last byte is the one that remains.
- R6: When bit 7 is 1, the data bytes go to consecutive indices. Bytes aimed at indices 10 to 15 are acknowledged but discarded, and after index 15 the index wraps to 0.
- R7: Indices 2 and 6 have no storage. They read as 0x00 on the output bus and ignore writes.
- R8: After reset, the registers at indices 0,1,3,4,5,7,8,9 hold 0x3F,0x3E,0x1E,0xEF,0x7F,0x7F,0x7F,0x06. `regs_o[8*i+7:8*i]` carries index i.
- R9: `sda_oe` goes high only after the SCL fall that ends the eighth bit of an acknowledged byte. It goes low again after the SCL fall that ends the ninth clock.
- R10: STOP ends the transfer. After STOP, bytes sent without a new START are ignored and are not acknowledged.
- R11: A START that arrives before a data byte is complete discards the partial byte, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed at the pin |
| sda_i | input | 1 | Bus data line as sensed at the pin |
| addr_sel | input | 1 | Strap that selects address bit 1 |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| regs_o | output | 80 | Contents of all ten register slots, index i at bits 8i+7..8i |

## Verification
In auto-increment mode, three things are settled on the same completed byte: the index wraps past 15, bytes aimed at indices 10 to 15 are discarded, and the acknowledge is still driven. The bench provokes this with a long burst that starts at index 8 and runs through the empty range into indices 0 and 1. A behavioural model predicts the acknowledge and the contents of the register bank, and the bench compares both on every clock. A START sent in the middle of a byte and a repeated START sent in the middle of a transfer are judged the same way: the model's registers stay unchanged, and the next address is acknowledged.

// File: rtl/audctl_pkg.sv
package audctl_pkg;

    localparam int DATA_W   = 8;
    localparam int IDX_W    = 4;
    localparam int NREG     = 10;
    localparam logic [5:0] DEV_ADDR_HI = 6'b100000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_SKIP
    } bus_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_events_t;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic slot_present(input int i);
        return !(i == 2 || i == 6);
    endfunction

    function automatic logic [DATA_W-1:0] slot_reset(input int i);
        case (i)
            0:       return 8'h3F;
            1:       return 8'h3E;
            3:       return 8'h1E;
            4:       return 8'hEF;
            5, 7, 8: return 8'h7F;
            9:       return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/audctl_line_sync.sv
module audctl_line_sync
    import audctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output bus_events_t ev
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[TOP];
    assign sda_s = sda_ff[TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.sda      = sda_s;
    end

    AST_COND_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |-> !(ev.scl_rise || ev.scl_fall)); // R1

endmodule

// File: rtl/audctl_bus_fsm.sv
module audctl_bus_fsm
    import audctl_pkg::*;
#(
    parameter int NSLOT = NREG
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_events_t ev,
    input  logic        addr_sel,
    output logic        sda_oe,
    output wr_req_t     wr
);
    localparam logic [IDX_W:0] SLOT_LIM = (IDX_W+1)'(NSLOT);

    bus_phase_e        phase;
    logic [3:0]        cnt;
    logic [DATA_W-1:0] shreg;
    logic              in_ack;
    logic [IDX_W-1:0]  idx;
    logic              inc;
    logic              addr_ok;
    logic              idx_live;

    assign addr_ok  = (shreg[7:1] == {DEV_ADDR_HI, addr_sel}) && !shreg[0];
    assign idx_live = ({1'b0, idx} < SLOT_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            in_ack <= 1'b0;
            idx    <= '0;
            inc    <= 1'b0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                phase  <= PH_ADDR;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.scl_rise && !in_ack && cnt < 4'd8) begin
                    shreg <= {shreg[DATA_W-2:0], ev.sda};
                    cnt   <= cnt + 4'd1;
                end else if (ev.scl_fall) begin
                    if (in_ack) begin
                        in_ack <= 1'b0;
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                    end else if (cnt == 4'd8) begin
                        in_ack <= 1'b1;
                        unique case (phase)
                            PH_ADDR: begin
                                sda_oe <= addr_ok;
                                phase  <= addr_ok ? PH_SUB : PH_SKIP;
                            end
                            PH_SUB: begin
                                sda_oe <= 1'b1;
                                idx    <= shreg[IDX_W-1:0];
                                inc    <= shreg[7];
                                phase  <= PH_DATA;
                            end
                            PH_DATA: begin
                                sda_oe  <= 1'b1;
                                wr.en   <= idx_live;
                                wr.idx  <= idx;
                                wr.data <= shreg;
                                if (inc) idx <= idx + 1'b1;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end
                end
            end
        end
    end

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (in_ack && ev.scl_fall && !ev.start && !ev.stop) |=> !sda_oe); // R9
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !sda_oe); // R3
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (phase == PH_IDLE && !sda_oe)); // R10
    AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == PH_ADDR && !wr.en)); // R11
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> !wr.en); // R5

endmodule

// File: rtl/audctl_regbank.sv
module audctl_regbank
    import audctl_pkg::*;
#(
    parameter int NSLOT = NREG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr,
    output logic [NSLOT*DATA_W-1:0] regs_o
);
    localparam logic [IDX_W:0] SLOT_LIM = (IDX_W+1)'(NSLOT);

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            if (slot_present(i)) begin : g_store
                logic [DATA_W-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst)
                        q <= slot_reset(i);
                    else if (wr.en && wr.idx == IDX_W'(i))
                        q <= wr.data;
                end
                assign regs_o[i*DATA_W +: DATA_W] = q;
            end else begin : g_empty
                assign regs_o[i*DATA_W +: DATA_W] = '0;
            end
        end
    endgenerate

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> ({1'b0, wr.idx} < SLOT_LIM)); // R6

endmodule

// File: rtl/audctl_i2c_slave.sv
module audctl_i2c_slave
    import audctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NSLOT       = NREG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    addr_sel,
    output logic                    sda_oe,
    output logic [NSLOT*DATA_W-1:0] regs_o
);
    bus_events_t ev;
    wr_req_t     wr;

    audctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    audctl_bus_fsm #(.NSLOT(NSLOT)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .wr       (wr)
    );

    audctl_regbank #(.NSLOT(NSLOT)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .regs_o (regs_o)
    );

endmodule

// File: tb/audctl_i2c_slave_tb.sv
module audctl_i2c_slave_tb;
    localparam int N = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic asel = 1'b0;
    logic sda_oe;
    logic [N*8-1:0] regs_o;
    wire  sda_line = sda_h & ~sda_oe;

    always #5 clk = ~clk;

    audctl_i2c_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .addr_sel(asel), .sda_oe(sda_oe), .regs_o(regs_o)
    );

    int compared = 0;
    int mismatched = 0;
    logic [7:0] mreg [N];
    int  ph = 0;       // 0 idle, 1 addr, 2 sub, 3 data, 4 skip
    int  midx = 0;
    bit  minc = 0;
    bit  exp_oe = 0;
    bit  cmp_en = 0;
    string cur_req = "R8";

    function automatic logic [N*8-1:0] model_bus();
        logic [N*8-1:0] v;
        for (int i = 0; i < N; i++) v[i*8 +: 8] = mreg[i];
        return v;
    endfunction

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            compared++;
            if (regs_o !== model_bus()) begin
                mismatched++;
                $display("FAIL %s regs actual=%h expected=%h", cur_req, regs_o, model_bus());
            end
            compared++;
            if (sda_oe !== exp_oe) begin
                mismatched++;
                $display("FAIL %s sda_oe actual=%b expected=%b", cur_req, sda_oe, exp_oe);
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wclk(5);
        scl = 1'b1;   wclk(10);
        sda_h = 1'b0; wclk(10);
        scl = 1'b0;   wclk(5);
        ph = 1;
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wclk(5);
        scl = 1'b1;   wclk(10);
        sda_h = 1'b1; wclk(10);
        ph = 0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int k = 7; k > 7 - n; k--) begin
            wclk(5); sda_h = b[k];
            wclk(5); scl = 1'b1;
            wclk(10); scl = 1'b0;
        end
    endtask

    // model decision at the end of the eighth bit
    task automatic model_byte(input logic [7:0] b, output bit ack);
        ack = 0;
        case (ph)
            1: if (b[7:1] == {6'b100000, asel} && !b[0]) begin ack = 1; ph = 2; end
               else ph = 4;
            2: begin midx = b[3:0]; minc = b[7]; ack = 1; ph = 3; end
            3: begin
                ack = 1;
                if (midx < N && midx != 2 && midx != 6) mreg[midx] = b;
                if (minc) midx = (midx + 1) % 16;
            end
            default: ack = 0;
        endcase
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit ack;
        send_bits(b, 8);
        cmp_en = 0;
        model_byte(b, ack);
        exp_oe = ack;
        wclk(5); sda_h = 1'b1;
        wclk(5); cmp_en = 1;
        scl = 1'b1; wclk(5);
        @(negedge clk);
        compared++;
        if (sda_oe !== ack) begin
            mismatched++;
            $display("FAIL %s ack actual=%b expected=%b byte=%h", cur_req, sda_oe, ack, b);
        end
        wclk(5);
        scl = 1'b0; cmp_en = 0; exp_oe = 0;
        wclk(8); cmp_en = 1;
    endtask

    task automatic check_slot(input int i, input logic [7:0] e, input string req);
        @(negedge clk);
        compared++;
        if (regs_o[i*8 +: 8] !== e) begin
            mismatched++;
            $display("FAIL %s slot %0d actual=%h expected=%h", req, i, regs_o[i*8 +: 8], e);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        summary_and_end();
    end

    initial begin
        mreg = '{8'h3F, 8'h3E, 8'h00, 8'h1E, 8'hEF, 8'h7F, 8'h00, 8'h7F, 8'h7F, 8'h06};
        wclk(4); rst = 1'b0; wclk(4);
        cur_req = "R8";
        check_slot(0, 8'h3F, "R8");
        check_slot(4, 8'hEF, "R8");
        check_slot(9, 8'h06, "R8");
        cmp_en = 1;

        // R2 R4 R5: no-increment, bits 6..4 of subaddress ignored
        cur_req = "R5";
        bus_start(); send_byte(8'h80); send_byte(8'h73);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h5A);
        bus_stop();
        check_slot(3, 8'h5A, "R5");

        // R6: increment from 8 through discarded 10..15, wrap to 0 and 1
        cur_req = "R6";
        bus_start(); send_byte(8'h80); send_byte(8'h88);
        for (int k = 0; k < 10; k++) send_byte(8'hA0 + k[7:0]);
        bus_stop();
        check_slot(8, 8'hA0, "R6");
        check_slot(0, 8'hA8, "R6");
        check_slot(1, 8'hA9, "R6");

        // R7: slot 2 and 6 have no storage
        cur_req = "R7";
        bus_start(); send_byte(8'h80); send_byte(8'h02); send_byte(8'h55); bus_stop();
        bus_start(); send_byte(8'h80); send_byte(8'h06); send_byte(8'h66); bus_stop();
        check_slot(2, 8'h00, "R7");
        check_slot(6, 8'h00, "R7");

        // R3: wrong address and read bit
        cur_req = "R3";
        bus_start(); send_byte(8'h82); send_byte(8'h04); send_byte(8'h12); bus_stop();
        bus_start(); send_byte(8'h81); send_byte(8'h04); send_byte(8'h12); bus_stop();
        check_slot(4, 8'hEF, "R3");

        // R2: strap selects address bit 1
        cur_req = "R2";
        asel = 1'b1;
        bus_start(); send_byte(8'h82); send_byte(8'h09); send_byte(8'hC3); bus_stop();
        bus_start(); send_byte(8'h80); send_byte(8'h09); send_byte(8'h3C); bus_stop();
        check_slot(9, 8'hC3, "R2");
        asel = 1'b0;

        // R1: repeated START inside a transfer
        cur_req = "R1";
        bus_start(); send_byte(8'h80); send_byte(8'h05); send_byte(8'h44);
        bus_start(); send_byte(8'h80); send_byte(8'h07); send_byte(8'h77);
        bus_stop();
        check_slot(5, 8'h44, "R1");
        check_slot(7, 8'h77, "R1");

        // R11: START in the middle of a data byte discards it
        cur_req = "R11";
        bus_start(); send_byte(8'h80); send_byte(8'h01);
        send_bits(8'hFF, 5);
        bus_start(); send_byte(8'h80); send_byte(8'h08); send_byte(8'h18);
        bus_stop();
        check_slot(1, 8'hA9, "R11");
        check_slot(8, 8'h18, "R11");

        // R10: bytes after STOP without START are ignored
        cur_req = "R10";
        scl = 1'b0; wclk(5);
        send_byte(8'h80); send_byte(8'h00); send_byte(8'h99);
        bus_stop();
        check_slot(0, 8'hA8, "R10");

        // R9: ack released after the ninth clock (checked per clock above)
        cur_req = "R9";
        bus_start(); send_byte(8'h80); send_byte(8'h84);
        send_byte(8'h01); send_byte(8'h02);
        bus_stop();
        check_slot(4, 8'h01, "R9");
        check_slot(5, 8'h02, "R9");

        cmp_en = 0;
        summary_and_end();
    end

endmodule